// File: doc/BRIEF.md
# Run-Time Selectable CRC Engine

This block computes a cyclic redundancy check over a stream of bytes, one byte per clock. It holds a 32-bit running remainder. An 8-bit mode register chooses one of three generator polynomials while the block runs.

Data is processed most-significant bit first. No bit reflection is applied on input or output. The remainder starts from all ones and is presented without a final XOR.

Any write to the mode register, and any pulse on the control strobe, reloads the seed before more data is folded in. A compare flag, when enabled, reports whether the current value differs from a 32-bit reference supplied on an input port.

Top module: `crc_sel_engine`

## Requirements
- R1: After reset, `crc_value` is 0xFFFFFFFF, `mode_q` is 0x00 and `crc_mismatch` is 0.
- R2: Mode register fields are as follows:
  - bit 0 enables processing.
  - bit 1 enables the compare flag.
  - bits 3:2 select the polynomial: 0 is CRC-32 (0x04C11DB7), 1 is CRC-32C (0x1EDC6F41), 2 is CRC-16-CCITT (0x1021), and 3 behaves as CRC-32.
  - bits 7:4 are a divider field that is stored and read back on `mode_q` but changes no result.
  - A write becomes visible on `mode_q` one cycle after `mode_wr`.
- R3: With selection 0, the bytes of the ASCII string "123456789" give 0x0376E6E7. Processing is MSB first, with no reflection and no final XOR.
- R4: With selection 1, each accepted byte updates the remainder by polynomial division with 0x1EDC6F41. Each byte is fed MSB first against the top bit of the remainder.
- R5: With selection 2, only bits 15:0 are used and bits 31:16 read as zero. The seed is 0x0000FFFF, and "123456789" gives 0x000029B1.
- R6: A byte presented with `data_valid` is reflected on `crc_value` one cycle later. Bytes on consecutive cycles are all accepted without a gap.
- R7: When the enable bit is 0, bytes presented with `data_valid` leave `crc_value` unchanged.
- R8: A cycle with `mode_wr` or `ctrl_wr` high reloads the seed at the next edge. A byte presented in that same cycle is discarded.
- R9: `crc_mismatch` is registered. It is 1 exactly when, in the previous cycle, the compare bit was set and `crc_value` differed from `ref_crc`. It is 0 whenever compare was off.
- R10: A mode write that changes the selection reseeds with the seed of the newly written selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write value |
| ctrl_wr | input | 1 | Control write strobe; forces a reseed |
| data_valid | input | 1 | Data byte qualifier |
| data_byte | input | 8 | Data byte |
| ref_crc | input | 32 | Reference value for the compare flag |
| mode_q | output | 8 | Mode register readback |
| crc_value | output | 32 | Current remainder |
| crc_mismatch | output | 1 | Registered compare result |

## Verification
The standard check string is run through the engine under each of the three selections. This separates a wrong polynomial, a wrong bit order and a wrong lane width, because each gives a different known result. The reserved selection and a non-zero divider field are run with the same string to show they change nothing.

Bytes sent back-to-back against a bench model show whether any byte is lost. A byte sent with enable low, and a byte sent in the same cycle as a control strobe, show whether data wrongly wins over the gating and the reseed. The reference value is toggled between equal and unequal with compare on and off; this exercises the flag's truth table and its one-cycle lag.

// File: rtl/crc_sel_pkg.sv
package crc_sel_pkg;
  localparam int CRC_W    = 32;
  localparam int NARROW_W = 16;
  localparam int DATA_W   = 8;
  localparam int MODE_W   = 8;

  typedef enum logic [1:0] {
    SEL_C32  = 2'd0,
    SEL_C32C = 2'd1,
    SEL_C16  = 2'd2,
    SEL_RSVD = 2'd3
  } poly_sel_e;

  // Field order fixes the bit positions: divider[7:4], sel[3:2], cmp[1], en[0]
  typedef struct packed {
    logic [3:0] divider;
    poly_sel_e  sel;
    logic       cmp_en;
    logic       enable;
  } mode_reg_t;

  function automatic logic is_narrow(input poly_sel_e s);
    return (s == SEL_C16);
  endfunction

  function automatic logic [CRC_W-1:0] poly_of(input poly_sel_e s);
    logic [CRC_W-1:0] p;
    case (s)
      SEL_C32C: p = 32'h1EDC_6F41;
      SEL_C16:  p = 32'h0000_1021;
      default:  p = 32'h04C1_1DB7;
    endcase
    return p;
  endfunction

  function automatic logic [CRC_W-1:0] seed_of(input poly_sel_e s);
    return is_narrow(s) ? {{(CRC_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}}
                        : {CRC_W{1'b1}};
  endfunction
endpackage

// File: rtl/crc_sel_cfg.sv
module crc_sel_cfg
  import crc_sel_pkg::*;
#(
  parameter int MODE_BITS = MODE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_wr,
  input  logic [MODE_BITS-1:0] mode_wdata,
  input  logic                 ctrl_wr,
  output mode_reg_t            mode_q,
  output logic                 reinit,
  output poly_sel_e            next_sel
);
  mode_reg_t mode_r;
  mode_reg_t wr_view;

  always_comb begin
    wr_view  = mode_reg_t'(mode_wdata);
    reinit   = mode_wr | ctrl_wr;
    next_sel = mode_wr ? wr_view.sel : mode_r.sel;
  end

  always_ff @(posedge clk) begin
    if (rst)          mode_r <= '0;
    else if (mode_wr) mode_r <= wr_view;
  end

  assign mode_q = mode_r;

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_wr |=> $stable(mode_r));
endmodule

// File: rtl/crc_sel_lane.sv
module crc_sel_lane #(
  parameter int W     = 32,
  parameter int DBITS = 8
) (
  input  logic [W-1:0]     rem_in,
  input  logic [W-1:0]     poly,
  input  logic [DBITS-1:0] din,
  output logic [W-1:0]     rem_out
);
  logic [W-1:0] stage [DBITS+1];

  assign stage[0] = rem_in;

  for (genvar i = 0; i < DBITS; i++) begin : g_bit
    logic fb;
    assign fb = stage[i][W-1] ^ din[DBITS-1-i];
    assign stage[i+1] = fb ? ({stage[i][W-2:0], 1'b0} ^ poly)
                           : {stage[i][W-2:0], 1'b0};
  end

  assign rem_out = stage[DBITS];
endmodule

// File: rtl/crc_sel_step.sv
module crc_sel_step
  import crc_sel_pkg::*;
#(
  parameter int WIDE   = CRC_W,
  parameter int NARROW = NARROW_W,
  parameter int DBITS  = DATA_W
) (
  input  logic [WIDE-1:0]  rem_in,
  input  logic [WIDE-1:0]  poly,
  input  logic             narrow,
  input  logic [DBITS-1:0] din,
  output logic [WIDE-1:0]  rem_out
);
  localparam int PAD = WIDE - NARROW;

  logic [WIDE-1:0]   wide_out;
  logic [NARROW-1:0] narrow_out;

  crc_sel_lane #(.W(WIDE), .DBITS(DBITS)) u_wide (
    .rem_in (rem_in),
    .poly   (poly),
    .din    (din),
    .rem_out(wide_out)
  );

  crc_sel_lane #(.W(NARROW), .DBITS(DBITS)) u_narrow (
    .rem_in (rem_in[NARROW-1:0]),
    .poly   (poly[NARROW-1:0]),
    .din    (din),
    .rem_out(narrow_out)
  );

  assign rem_out = narrow ? {{PAD{1'b0}}, narrow_out} : wide_out;
endmodule

// File: rtl/crc_sel_core.sv
module crc_sel_core
  import crc_sel_pkg::*;
#(
  parameter int WIDE   = CRC_W,
  parameter int NARROW = NARROW_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reinit,
  input  logic [WIDE-1:0] seed_in,
  input  logic            accept,
  input  logic            narrow,
  input  logic [WIDE-1:0] step_val,
  output logic [WIDE-1:0] rem_q
);
  always_ff @(posedge clk) begin
    if (rst)         rem_q <= {WIDE{1'b1}};
    else if (reinit) rem_q <= seed_in;
    else if (accept) rem_q <= step_val;
  end

  // R8
  reseed_chk: assert property (@(posedge clk) disable iff (rst)
    reinit |=> rem_q == $past(seed_in));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!reinit && !accept) |=> $stable(rem_q));

  // R5
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    narrow |-> rem_q[WIDE-1:NARROW] == '0);
endmodule

// File: rtl/crc_sel_engine.sv
module crc_sel_engine
  import crc_sel_pkg::*;
#(
  parameter int DBITS  = DATA_W,
  parameter int WIDE   = CRC_W,
  parameter int NARROW = NARROW_W,
  parameter int MBITS  = MODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr,
  input  logic [MBITS-1:0] mode_wdata,
  input  logic             ctrl_wr,
  input  logic             data_valid,
  input  logic [DBITS-1:0] data_byte,
  input  logic [WIDE-1:0]  ref_crc,
  output logic [MBITS-1:0] mode_q,
  output logic [WIDE-1:0]  crc_value,
  output logic             crc_mismatch
);
  mode_reg_t       mode_r;
  logic            reinit;
  poly_sel_e       next_sel;
  logic            narrow;
  logic            accept;
  logic [WIDE-1:0] poly;
  logic [WIDE-1:0] seed;
  logic [WIDE-1:0] step_val;
  logic [WIDE-1:0] rem_q;
  logic            mismatch_q;

  crc_sel_cfg #(.MODE_BITS(MBITS)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .mode_wr   (mode_wr),
    .mode_wdata(mode_wdata),
    .ctrl_wr   (ctrl_wr),
    .mode_q    (mode_r),
    .reinit    (reinit),
    .next_sel  (next_sel)
  );

  always_comb begin
    narrow = is_narrow(mode_r.sel);
    poly   = poly_of(mode_r.sel);
    seed   = seed_of(next_sel);
    accept = data_valid & mode_r.enable;
  end

  crc_sel_step #(.WIDE(WIDE), .NARROW(NARROW), .DBITS(DBITS)) u_step (
    .rem_in (rem_q),
    .poly   (poly),
    .narrow (narrow),
    .din    (data_byte),
    .rem_out(step_val)
  );

  crc_sel_core #(.WIDE(WIDE), .NARROW(NARROW)) u_core (
    .clk     (clk),
    .rst     (rst),
    .reinit  (reinit),
    .seed_in (seed),
    .accept  (accept),
    .narrow  (narrow),
    .step_val(step_val),
    .rem_q   (rem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) mismatch_q <= 1'b0;
    else     mismatch_q <= mode_r.cmp_en & (rem_q != ref_crc);
  end

  assign mode_q       = mode_r;
  assign crc_value    = rem_q;
  assign crc_mismatch = mismatch_q;

  // R9
  cmp_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_r.cmp_en |=> !mismatch_q);
endmodule

// File: tb/crc_sel_engine_bench.sv
`timescale 1ns/1ps
module crc_sel_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_wr = 1'b0;
  logic [7:0]  mode_wdata = '0;
  logic        ctrl_wr = 1'b0;
  logic        data_valid = 1'b0;
  logic [7:0]  data_byte = '0;
  logic [31:0] ref_crc = '0;
  logic [7:0]  mode_q;
  logic [31:0] crc_value;
  logic        crc_mismatch;

  always #2 clk = ~clk;

  crc_sel_engine u_crc_sel_engine (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .ctrl_wr(ctrl_wr), .data_valid(data_valid), .data_byte(data_byte),
    .ref_crc(ref_crc), .mode_q(mode_q), .crc_value(crc_value),
    .crc_mismatch(crc_mismatch)
  );

  typedef struct {
    int          due;
    int          kind;   // 0 crc_value, 1 mode_q, 2 crc_mismatch
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t it;
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] m_crc = 32'hFFFF_FFFF;
  logic [1:0]  m_sel = 2'd0;
  logic        m_en  = 1'b0;
  logic [7:0]  chk_str [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35,
                               8'h36, 8'h37, 8'h38, 8'h39};

  function automatic logic [31:0] ref_step(logic [31:0] r, logic [7:0] b,
                                           logic [1:0] s);
    logic [15:0] r16;
    logic [31:0] p;
    if (s == 2'd2) begin
      r16 = r[15:0] ^ {b, 8'h00};
      for (int k = 0; k < 8; k++)
        r16 = r16[15] ? ((r16 << 1) ^ 16'h1021) : (r16 << 1);
      return {16'h0000, r16};
    end
    p = (s == 2'd1) ? 32'h1EDC_6F41 : 32'h04C1_1DB7;
    r = r ^ {b, 24'h0};
    for (int k = 0; k < 8; k++)
      r = r[31] ? ((r << 1) ^ p) : (r << 1);
    return r;
  endfunction

  task automatic push(int d, int k, logic [31:0] v, string t);
    exp_t e;
    e.due = d; e.kind = k; e.val = v; e.tag = t;
    q.push_back(e);
  endtask

  // monitor: pops expected items when their cycle arrives
  always @(negedge clk) begin
    cyc++;
    while (q.size() > 0 && q[0].due <= cyc) begin
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = crc_value;
        1:       act = {24'h0, mode_q};
        default: act = {31'h0, crc_mismatch};
      endcase
      n_chk++;
      if (act !== it.val) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h (cycle %0d)",
                 it.tag, act, it.val, cyc);
      end
    end
  end

  task automatic drive(logic mw, logic [7:0] md, logic cw, logic dv,
                       logic [7:0] db, string t);
    @(negedge clk); #1;
    mode_wr = mw; mode_wdata = md; ctrl_wr = cw;
    data_valid = dv; data_byte = db;
    if (mw || cw) begin
      if (mw) begin m_sel = md[3:2]; m_en = md[0]; end
      m_crc = (m_sel == 2'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    end else if (dv && m_en) begin
      m_crc = ref_step(m_crc, db, m_sel);
    end
    push(cyc + 1, 0, m_crc, t);
    if (mw) push(cyc + 1, 1, {24'h0, md}, t);
  endtask

  task automatic t_mode(logic [7:0] v, string t);
    drive(1'b1, v, 1'b0, 1'b0, 8'h00, t);
  endtask

  task automatic t_byte(logic [7:0] b, string t);
    drive(1'b0, 8'h00, 1'b0, 1'b1, b, t);
  endtask

  task automatic t_expect(logic [31:0] v, string t);
    drive(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, t);
    push(cyc + 1, 0, v, t);
  endtask

  task automatic t_mm(logic [31:0] r, logic e, string t);
    @(negedge clk); #1;
    mode_wr = 0; ctrl_wr = 0; data_valid = 0; ref_crc = r;
    push(cyc + 1, 2, {31'h0, e}, t);
  endtask

  task automatic t_string(string t);
    for (int i = 0; i < 9; i++) t_byte(chk_str[i], t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    push(cyc + 1, 0, 32'hFFFF_FFFF, "R1 reset crc");
    push(cyc + 1, 1, 32'h0, "R1 reset mode");
    push(cyc + 1, 2, 32'h0, "R1 reset mismatch");

    // R7: disabled engine ignores data
    t_byte(8'h55, "R7 byte while disabled");
    t_byte(8'hA3, "R7 byte while disabled");

    // R3 / R6: CRC-32 on the check string, back-to-back
    t_mode(8'h01, "R10 seed after mode write");
    t_string("R6 back-to-back crc32");
    t_expect(32'h0376_E6E7, "R3 crc32 check value");

    // R9: compare off then on
    t_mm(32'h0, 1'b0, "R9 compare off, values differ");
    t_mode(8'h03, "R8 reseed on mode write");
    t_mm(32'hFFFF_FFFF, 1'b0, "R9 compare on, equal");
    t_mm(32'h1234_5678, 1'b1, "R9 compare on, differ");
    t_mm(32'hFFFF_FFFF, 1'b0, "R9 compare on, equal again");

    // R5 / R10 / R2: CRC-16 with divider bits set
    t_mode(8'hF9, "R10 reseed to 16-bit seed");
    t_string("R5 crc16 stream");
    t_expect(32'h0000_29B1, "R5 crc16 check value");
    t_mode(8'h09, "R2 divider cleared");
    t_string("R2 divider no effect");
    t_expect(32'h0000_29B1, "R2 divider no effect value");

    // R4: CRC-32C against the bench model
    t_mode(8'h05, "R10 reseed to 32-bit seed");
    t_string("R4 crc32c stream");
    t_byte(8'h00, "R4 crc32c zero byte");
    t_byte(8'hFF, "R4 crc32c ones byte");

    // R8: control write discards same-cycle byte, then stream resumes
    drive(1'b0, 8'h00, 1'b1, 1'b1, 8'h5A, "R8 ctrl write drops byte");
    t_expect(32'hFFFF_FFFF, "R8 seed after ctrl write");
    t_byte(8'h5A, "R8 byte after reseed");
    drive(1'b1, 8'h01, 1'b0, 1'b1, 8'hC3, "R8 mode write drops byte");

    // R2: reserved selection behaves as CRC-32
    t_mode(8'h0D, "R2 reserved selection");
    t_string("R2 reserved selection stream");
    t_expect(32'h0376_E6E7, "R2 reserved selection value");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #40000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule